// File: doc/BRIEF.md
# Timed transmit event sequencer

This block schedules the control strobes of one burst transmission inside a time slot. A static table of eight entries, given as configuration inputs, holds an event code and a delay in ticks for each entry. Each delay counts from the firing of the entry before it, so the offsets add up along the table. Entries 0 to 4 form the first group. This group starts at an accepted slot-start pulse, after a programmable start offset. Entries 5 to 7 form the second group, which starts at the pulse that marks the last message bit handed to the modulator.

The events open and close a carrier-sense listening window, start and end modulation, ramp the power DAC up and down, and raise the transmit-enable line. The line is dropped a programmed number of ticks after the ramp-down begins. A signal detected during the listening window cancels the burst. The block checks the table's ordering rules and refuses to start on a bad table.

Top module: `tx_event_seq`

## Requirements
- R1: After reset, every event strobe, `txEnable`, `busy`, `done`, `aborted` and `tableErr` (with a valid table) are low.
- R2: Event codes are 3 bits: 0 no action, 1 listen start (`csMonStart`), 2 listen stop (`csMonStop`), 3 raise `txEnable`, 4 ramp up (`rampUp`), 5 modulate start (`modStart`), 6 ramp down (`rampDown`), 7 modulate end (`modEnd`). Each fired entry gives one single-cycle strobe, and at most one strobe is high in any cycle.
- R3: An entry of the first group fires after `startOffset` plus the sum of the delays of entries 0 up to itself have elapsed, counted in `tickEn` pulses from the accepted `slotStart`.
- R4: An entry with delay 0 fires within the same tick interval as the entry before it, one clock later, keeping table order.
- R5: An entry of the second group fires after the sum of the delays of entries 5 up to itself have elapsed, counted in ticks from `msgDone`. The second group starts only after the first group has finished.
- R6: `txEnable` rises when code 3 fires. It falls `rampHold` ticks after the ramp-down strobe, or in the same cycle as that strobe when `rampHold` is 0.
- R7: `csDetect` high while the listening window is open (after code 1 has fired and before code 2 has fired) aborts the burst. In the next cycle `aborted` is high and `busy` and `txEnable` are low. No further event fires, and `msgDone` is then ignored. `csDetect` outside the window has no effect. `aborted` clears when the next sequence starts.
- R8: A `slotStart` pulse that arrives while `busy` is high is ignored.
- R9: `tableErr` is high when code 2 appears with no code 1 before it, when code 5 lies in entries 5 to 7, or when code 7 lies in entries 0 to 4 or has no code 5 before it. While `tableErr` is high, `slotStart` starts nothing.
- R10: After the last entry has fired and `txEnable` has dropped, `done` pulses for one cycle and `busy` falls.
- R11: Code 0 entries take up their delay but drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tickEn | input | 1 | One-cycle tick that advances all delay counters |
| slotStart | input | 1 | Slot-start pulse |
| msgDone | input | 1 | Pulse at the end of the last message bit |
| csDetect | input | 1 | Carrier-sense detection |
| startOffset | input | DLY_W | Ticks from slot start to the first group |
| rampHold | input | DLY_W | Ticks that transmit-enable stays high after ramp-down |
| evCodes | input | 3*NUM_ENTRIES | Event code of entry j at bits [3j+2:3j] |
| evDelays | input | DLY_W*NUM_ENTRIES | Delay of entry j at bits [DLY_W*j+DLY_W-1:DLY_W*j] |
| csMonStart | output | 1 | Listen-window start strobe |
| csMonStop | output | 1 | Listen-window stop strobe |
| txEnable | output | 1 | Transmit-enable level |
| rampUp | output | 1 | Power ramp-up strobe |
| rampDown | output | 1 | Power ramp-down strobe |
| modStart | output | 1 | Modulate start strobe |
| modEnd | output | 1 | Modulate end strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed pulse |
| aborted | output | 1 | Last sequence was cancelled |
| tableErr | output | 1 | Table ordering violation |

## Verification
The bench sweeps sixteen delay patterns over two valid table orders. The delays mix zero and non-zero values, with start offsets of 0 to 2 and hold times of 0 to 3 and 7. This separates correct accumulation of delays from counting each entry alone, and zero-delay chaining from a wrongly consumed tick. Each event's tick count is compared with the running sum for its group. A second table order, with ramp-down placed last, shows that the final hold is observed before completion. Abort runs with transmit-enable already high, and detection pulses outside the window, tell a real cancellation apart from a spurious one. Five crafted tables cover each ordering error and the valid case.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [2:0] {
    EV_NOP       = 3'd0,
    EV_CS_ON     = 3'd1,
    EV_CS_OFF    = 3'd2,
    EV_TX_ON     = 3'd3,
    EV_RAMP_UP   = 3'd4,
    EV_MOD_ON    = 3'd5,
    EV_RAMP_DOWN = 3'd6,
    EV_MOD_OFF   = 3'd7
  } evCode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_OFFSET, S_GRP1, S_WAITMSG, S_GRP2, S_DRAIN
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadOffset;
    logic loadEntry;
    logic fire;
    logic abortNow;
    logic finish;
  } seqCtl_t;

endpackage

// File: rtl/tx_seq_check.sv
module tx_seq_check
  import tx_seq_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int FIRST_GROUP = 5
) (
  input  logic [3*NUM_ENTRIES-1:0] evCodes,
  output logic                     tableErr
);

  evCode_t codeArr [NUM_ENTRIES];

  for (genvar j = 0; j < NUM_ENTRIES; j++) begin : g_unpack
    assign codeArr[j] = evCode_t'(evCodes[3*j +: 3]);
  end

  logic seenCs;
  logic seenMod;

  always_comb begin
    seenCs   = 1'b0;
    seenMod  = 1'b0;
    tableErr = 1'b0;
    for (int j = 0; j < NUM_ENTRIES; j++) begin
      if (codeArr[j] == EV_CS_OFF && !seenCs) tableErr = 1'b1;
      if (codeArr[j] == EV_MOD_ON && j >= FIRST_GROUP) tableErr = 1'b1;
      if (codeArr[j] == EV_MOD_OFF && (j < FIRST_GROUP || !seenMod)) tableErr = 1'b1;
      if (codeArr[j] == EV_CS_ON) seenCs = 1'b1;
      if (codeArr[j] == EV_MOD_ON) seenMod = 1'b1;
    end
  end

endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import tx_seq_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int FIRST_GROUP = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           slotStart,
  input  logic                           msgDone,
  input  logic                           csDetect,
  input  logic                           tableErr,
  input  logic                           cntZero,
  input  logic                           holdBusy,
  input  logic                           csActive,
  output seqCtl_t                        ctl,
  output logic [$clog2(NUM_ENTRIES)-1:0] curIdx,
  output logic [$clog2(NUM_ENTRIES)-1:0] loadIdx,
  output logic                           busy,
  output logic                           done,
  output logic                           aborted
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [IDX_W-1:0] LAST1 = IDX_W'(FIRST_GROUP - 1);
  localparam logic [IDX_W-1:0] FIRST2 = IDX_W'(FIRST_GROUP);
  localparam logic [IDX_W-1:0] LAST2 = IDX_W'(NUM_ENTRIES - 1);

  seqState_t state, nextState;
  logic [IDX_W-1:0] idx, nextIdx;
  logic abortCond;

  assign abortCond = csActive && csDetect &&
                     (state == S_OFFSET || state == S_GRP1 || state == S_WAITMSG);

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextIdx   = idx;
    loadIdx   = idx;
    if (abortCond) begin
      ctl.abortNow = 1'b1;
      nextState    = S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (slotStart && !tableErr) begin
          ctl.loadOffset = 1'b1;
          nextIdx        = '0;
          nextState      = S_OFFSET;
        end
        S_OFFSET: if (cntZero) begin
          ctl.loadEntry = 1'b1;
          loadIdx       = '0;
          nextState     = S_GRP1;
        end
        S_GRP1: if (cntZero) begin
          ctl.fire = 1'b1;
          if (idx == LAST1) nextState = S_WAITMSG;
          else begin
            nextIdx       = idx + 1'b1;
            loadIdx       = idx + 1'b1;
            ctl.loadEntry = 1'b1;
          end
        end
        S_WAITMSG: if (msgDone) begin
          ctl.loadEntry = 1'b1;
          loadIdx       = FIRST2;
          nextIdx       = FIRST2;
          nextState     = S_GRP2;
        end
        S_GRP2: if (cntZero) begin
          ctl.fire = 1'b1;
          if (idx == LAST2) nextState = S_DRAIN;
          else begin
            nextIdx       = idx + 1'b1;
            loadIdx       = idx + 1'b1;
            ctl.loadEntry = 1'b1;
          end
        end
        S_DRAIN: if (!holdBusy) begin
          ctl.finish = 1'b1;
          nextState  = S_IDLE;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      done    <= 1'b0;
      aborted <= 1'b0;
    end else begin
      state <= nextState;
      idx   <= nextIdx;
      done  <= ctl.finish;
      if (ctl.abortNow) aborted <= 1'b1;
      else if (ctl.loadOffset) aborted <= 1'b0;
    end
  end

  assign busy   = (state != S_IDLE);
  assign curIdx = idx;

  p_restart_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slotStart && !ctl.finish && !ctl.abortNow) |=> (busy && $stable(aborted)));

  p_bad_table_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && slotStart && tableErr) |=> !busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_abort_to_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aborted) |-> !busy);

endmodule

// File: rtl/tx_seq_datapath.sv
module tx_seq_datapath
  import tx_seq_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int DLY_W       = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickEn,
  input  seqCtl_t                        ctl,
  input  logic [$clog2(NUM_ENTRIES)-1:0] curIdx,
  input  logic [$clog2(NUM_ENTRIES)-1:0] loadIdx,
  input  logic [DLY_W-1:0]               startOffset,
  input  logic [DLY_W-1:0]               rampHold,
  input  logic [3*NUM_ENTRIES-1:0]       evCodes,
  input  logic [DLY_W*NUM_ENTRIES-1:0]   evDelays,
  output logic                           cntZero,
  output logic                           holdBusy,
  output logic                           csActive,
  output logic                           csMonStart,
  output logic                           csMonStop,
  output logic                           txEnable,
  output logic                           rampUp,
  output logic                           rampDown,
  output logic                           modStart,
  output logic                           modEnd
);

  evCode_t          codeArr [NUM_ENTRIES];
  logic [DLY_W-1:0] dlyArr  [NUM_ENTRIES];

  for (genvar j = 0; j < NUM_ENTRIES; j++) begin : g_unpack
    assign codeArr[j] = evCode_t'(evCodes[3*j +: 3]);
    assign dlyArr[j]  = evDelays[DLY_W*j +: DLY_W];
  end

  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.loadOffset) cnt <= startOffset;
    else if (ctl.loadEntry) cnt <= dlyArr[loadIdx];
    else if (tickEn && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {csMonStart, csMonStop, rampUp, rampDown, modStart, modEnd} <= '0;
      txEnable <= 1'b0;
      csActive <= 1'b0;
      holdBusy <= 1'b0;
      holdCnt  <= '0;
    end else begin
      {csMonStart, csMonStop, rampUp, rampDown, modStart, modEnd} <= '0;
      if (ctl.abortNow || ctl.finish) begin
        txEnable <= 1'b0;
        csActive <= 1'b0;
        holdBusy <= 1'b0;
        holdCnt  <= '0;
      end else begin
        if (holdBusy && tickEn) begin
          holdCnt <= holdCnt - 1'b1;
          if (holdCnt <= 1) begin
            txEnable <= 1'b0;
            holdBusy <= 1'b0;
          end
        end
        if (ctl.fire) begin
          case (codeArr[curIdx])
            EV_CS_ON:   begin csMonStart <= 1'b1; csActive <= 1'b1; end
            EV_CS_OFF:  begin csMonStop <= 1'b1; csActive <= 1'b0; end
            EV_TX_ON:   txEnable <= 1'b1;
            EV_RAMP_UP: rampUp <= 1'b1;
            EV_MOD_ON:  modStart <= 1'b1;
            EV_MOD_OFF: modEnd <= 1'b1;
            EV_RAMP_DOWN: begin
              rampDown <= 1'b1;
              if (rampHold == '0) txEnable <= 1'b0;
              else begin
                holdBusy <= 1'b1;
                holdCnt  <= rampHold;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_single_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({csMonStart, csMonStop, rampUp, rampDown, modStart, modEnd}));

  p_count_waits_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadOffset && !ctl.loadEntry && !tickEn) |=> $stable(cnt));

  p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdBusy && !tickEn && !ctl.abortNow && !ctl.finish) |=> holdBusy);

  p_abort_drops_tx_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abortNow |=> (!txEnable && !csActive));

endmodule

// File: rtl/tx_event_seq.sv
module tx_event_seq
  import tx_seq_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int FIRST_GROUP = 5,
  parameter int DLY_W       = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tickEn,
  input  logic                         slotStart,
  input  logic                         msgDone,
  input  logic                         csDetect,
  input  logic [DLY_W-1:0]             startOffset,
  input  logic [DLY_W-1:0]             rampHold,
  input  logic [3*NUM_ENTRIES-1:0]     evCodes,
  input  logic [DLY_W*NUM_ENTRIES-1:0] evDelays,
  output logic                         csMonStart,
  output logic                         csMonStop,
  output logic                         txEnable,
  output logic                         rampUp,
  output logic                         rampDown,
  output logic                         modStart,
  output logic                         modEnd,
  output logic                         busy,
  output logic                         done,
  output logic                         aborted,
  output logic                         tableErr
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);

  seqCtl_t          ctl;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] loadIdx;
  logic             cntZero;
  logic             holdBusy;
  logic             csActive;

  tx_seq_check #(.NUM_ENTRIES(NUM_ENTRIES), .FIRST_GROUP(FIRST_GROUP)) u_check (
    .evCodes (evCodes),
    .tableErr(tableErr)
  );

  tx_seq_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .FIRST_GROUP(FIRST_GROUP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotStart(slotStart),
    .msgDone  (msgDone),
    .csDetect (csDetect),
    .tableErr (tableErr),
    .cntZero  (cntZero),
    .holdBusy (holdBusy),
    .csActive (csActive),
    .ctl      (ctl),
    .curIdx   (curIdx),
    .loadIdx  (loadIdx),
    .busy     (busy),
    .done     (done),
    .aborted  (aborted)
  );

  tx_seq_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .DLY_W(DLY_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .ctl        (ctl),
    .curIdx     (curIdx),
    .loadIdx    (loadIdx),
    .startOffset(startOffset),
    .rampHold   (rampHold),
    .evCodes    (evCodes),
    .evDelays   (evDelays),
    .cntZero    (cntZero),
    .holdBusy   (holdBusy),
    .csActive   (csActive),
    .csMonStart (csMonStart),
    .csMonStop  (csMonStop),
    .txEnable   (txEnable),
    .rampUp     (rampUp),
    .rampDown   (rampDown),
    .modStart   (modStart),
    .modEnd     (modEnd)
  );

endmodule

// File: tb/tb_tx_event_seq.sv
`timescale 1ns/1ps
module tb_tx_event_seq;

  localparam int NE = 8;
  localparam int FG = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, tickEn = 1'b0, slotStart = 1'b0, msgDone = 1'b0, csDetect = 1'b0;
  logic [DW-1:0] startOffset = '0, rampHold = '0;
  logic [3*NE-1:0] evCodes = '0;
  logic [DW*NE-1:0] evDelays = '0;
  logic csMonStart, csMonStop, txEnable, rampUp, rampDown, modStart, modEnd;
  logic busy, done, aborted, tableErr;

  tx_event_seq #(.NUM_ENTRIES(NE), .FIRST_GROUP(FG), .DLY_W(DW)) dut (.*);

  int checks = 0, fails = 0;
  int codeT [NE];
  int dlyT  [NE];
  int expT  [NE];
  int seen  [8];
  int offs, hold, ticks = 0, phase = 0;
  bit quiet = 0, doneSeen = 0, txPrev = 0, finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int entryOf(int c);
    for (int e = 0; e < NE; e++) if (codeT[e] == c) return e;
    return 0;
  endfunction

  task automatic loadTable();
    int cum;
    for (int e = 0; e < NE; e++) begin
      evCodes[3*e +: 3]    = 3'(codeT[e]);
      evDelays[DW*e +: DW] = DW'(dlyT[e]);
    end
    startOffset = DW'(offs);
    rampHold    = DW'(hold);
    cum = offs;
    for (int e = 0; e < FG; e++) begin cum += dlyT[e]; expT[e] = cum; end
    cum = 0;
    for (int e = FG; e < NE; e++) begin cum += dlyT[e]; expT[e] = cum; end
  endtask

  task automatic observe();
    logic [7:0] stb;
    stb = {modEnd, rampDown, modStart, rampUp, txEnable && !txPrev, csMonStop, csMonStart, 1'b0};
    for (int c = 1; c < 8; c++) begin
      if (stb[c]) begin
        if (quiet) check(0, "R7 event after abort", c, 0);
        else begin
          int e;
          e = entryOf(c);
          seen[c]++;
          if (dlyT[e] == 0) check(ticks == expT[e], "R4 zero-delay event tick", ticks, expT[e]);
          else if (e < FG) check(ticks == expT[e], "R3 first-group event tick", ticks, expT[e]);
          else check(ticks == expT[e], "R5 second-group event tick", ticks, expT[e]);
        end
      end
    end
    if (txPrev && !txEnable && !quiet)
      check(ticks == expT[entryOf(6)] + hold, "R6 txEnable fall tick", ticks, expT[entryOf(6)] + hold);
    if (done) doneSeen = 1;
    txPrev = txEnable;
  endtask

  task automatic step();
    @(negedge clk);
    if (tickEn) ticks++;
    observe();
    slotStart = 0; msgDone = 0; csDetect = 0;
    phase = (phase + 1) % 8;
    tickEn = (phase == 0);
  endtask

  task automatic syncPhase();
    while (phase != 1) step();
  endtask

  task automatic runNormal(int o, int h, bit noisy);
    offs = o; hold = h; loadTable();
    for (int c = 0; c < 8; c++) seen[c] = 0;
    doneSeen = 0;
    syncPhase();
    slotStart = 1; ticks = 0;
    step();
    check(busy == 1, "R3 busy after start", busy, 1);
    if (noisy) begin csDetect = 1; step(); end
    repeat (8 * (expT[FG-1] + 3)) step();
    check(busy == 1 && aborted == 0, "R7 waiting for message, no abort", {busy, aborted}, 2);
    slotStart = 1; step(); step();
    check(busy == 1, "R8 slot start ignored while busy", busy, 1);
    if (noisy) begin csDetect = 1; step(); end
    syncPhase();
    msgDone = 1; ticks = 0;
    for (int k = 0; k < 3000 && !doneSeen; k++) step();
    check(doneSeen, "R10 done pulse", doneSeen, 1);
    check(txEnable == 0, "R10 txEnable low at done", txEnable, 0);
    step();
    check(busy == 0 && done == 0, "R10 idle and done single", {busy, done}, 0);
    for (int c = 1; c < 8; c++) check(seen[c] == 1, "R2 one strobe per code (R11 no-op silent)", seen[c], 1);
  endtask

  task automatic setCodes(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7);
    codeT = '{c0, c1, c2, c3, c4, c5, c6, c7};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    setCodes(1, 5, 2, 3, 4, 6, 0, 7);
    dlyT = '{1, 1, 1, 1, 1, 1, 1, 1};
    offs = 0; hold = 0; loadTable();
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    check({csMonStart, csMonStop, txEnable, rampUp, rampDown, modStart, modEnd} == 0,
          "R1 strobes low after reset", 0, 0);
    check({busy, done, aborted, tableErr} == 0, "R1 status low after reset",
          {busy, done, aborted, tableErr}, 0);

    // sweep of delay patterns over two table orders
    for (int p = 0; p < 16; p++) begin
      if (p % 2 == 0) setCodes(1, 5, 2, 3, 4, 6, 0, 7);
      else            setCodes(1, 2, 5, 4, 3, 0, 7, 6);
      for (int k = 0; k < NE; k++) dlyT[k] = (p * 7 + k * 3 + (p / 2) * k) % 4;
      runNormal(p % 3, (p % 5 == 4) ? 7 : p % 4, 0);
    end

    // detection outside the window has no effect; aborted cleared by start
    setCodes(1, 3, 5, 2, 4, 6, 0, 7);
    dlyT = '{1, 1, 1, 3, 1, 0, 0, 0};
    offs = 0; hold = 0; loadTable();
    syncPhase();
    slotStart = 1; ticks = 0; step();
    while (!txEnable) step();
    quiet = 1; csDetect = 1; step();
    check(aborted == 1, "R7 aborted set", aborted, 1);
    check(busy == 0, "R7 idle after abort", busy, 0);
    check(txEnable == 0, "R7 txEnable dropped on abort", txEnable, 0);
    repeat (20) step();
    msgDone = 1;
    repeat (40) step();
    check(busy == 0, "R7 msgDone ignored after abort", busy, 0);
    quiet = 0; txPrev = txEnable;
    dlyT = '{2, 1, 1, 1, 1, 1, 2, 1};
    runNormal(2, 3, 1);
    check(aborted == 0, "R7 aborted cleared, outside detection ignored", aborted, 0);

    // table ordering errors
    quiet = 1;
    setCodes(2, 1, 5, 3, 4, 6, 0, 7); loadTable(); step();
    check(tableErr == 1, "R9 stop before start", tableErr, 1);
    slotStart = 1; step(); step();
    check(busy == 0, "R9 bad table not started", busy, 0);
    setCodes(1, 2, 3, 4, 0, 5, 6, 7); loadTable(); step();
    check(tableErr == 1, "R9 modulate start in second group", tableErr, 1);
    setCodes(1, 2, 7, 5, 3, 6, 4, 0); loadTable(); step();
    check(tableErr == 1, "R9 modulate end in first group", tableErr, 1);
    setCodes(1, 2, 3, 4, 0, 6, 0, 7); loadTable(); step();
    check(tableErr == 1, "R9 modulate end without start", tableErr, 1);
    setCodes(1, 5, 2, 3, 4, 6, 0, 7); loadTable(); step();
    check(tableErr == 0, "R9 valid table accepted", tableErr, 0);
    repeat (10) step();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule